// File: doc/BRIEF.md
# Linear CCD Readout Timing Generator

This block drives a linear CCD that shifts out one pixel for every two periods of its master clock. It produces a free-running square-wave master clock, performs the gate handshake that moves the integrated charge into the sensor's output register, and then issues one conversion strobe for an external ADC per pixel. It also counts the pixel slots of the frame. A frame holds leading dummy slots, image slots and trailing dummy slots, and every slot is always shifted out.

The gate handshake runs as follows. The clear gate goes low. After a short fixed gap the transfer gate pulses high. A minimum hold follows its falling edge. The clear gate then returns high exactly at a rising edge of the master clock, and the first strobe fires on that same edge. The falling edge of the transfer gate starts the next integration period, and its cycle number is captured as a timestamp. A new readout begins only while the start request is held and the integration time since that edge has reached a programmable minimum. All delays are set in nanoseconds and converted to system-clock cycles at elaboration. A parameter inverts the three sensor drive pins, for boards that buffer them through inverters.

Top module: `ccd_timing_gen`

## Requirements
- R1: The master clock is a 50% square wave with a half-period of H = ceil(FM_HALF_NS*SYS_CLK_MHZ/1000) system cycles. It is low out of reset, and it first rises H cycles after reset is released.
- R2: Under reset and while idle, the clear gate is high, the transfer gate is low, the strobe and frame pulses are low, and the pixel index is 0.
- R3: When a readout starts, the clear gate falls, and the transfer gate rises exactly L = ceil(LEAD_NS*SYS_CLK_MHZ/1000) cycles later.
- R4: The transfer gate stays high for exactly W = ceil(SH_HIGH_NS*SYS_CLK_MHZ/1000) cycles.
- R5: The clear gate rises on the first master-clock rising edge that comes at least T = ceil(TAIL_NS*SYS_CLK_MHZ/1000) cycles after the transfer gate falls. It rises in the same cycle as the master clock, and frame_start pulses for that one cycle.
- R6: A one-cycle strobe fires on the clear-gate rising edge and then on every second master-clock rising edge (every 4H cycles), never on the edges in between. The pixel index reads 0 with the first strobe, rises by one with each later strobe, and holds between strobes and after the frame.
- R7: A frame has N_LEAD+N_IMAGE+N_TRAIL strobes. frame_done pulses for one cycle, starting the cycle after the last strobe.
- R8: The block is idle again from the clock edge at which frame_done drops. From idle, the clear gate falls at the first clock edge where start_i is high and at least min_int_i cycles have passed since the edge after the last transfer-gate fall. Out of reset the minimum counts as already met.
- R9: integ_stamp_o holds the cycle number of the most recent transfer-gate falling edge. Edges are counted from 1 at the first edge after reset. It is 0 after reset.
- R10: With INVERT set, the master clock, clear gate and transfer gate pins carry the complement of their levels with INVERT clear. The strobe, index and frame pulses are not inverted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Readout request, sampled while idle |
| min_int_i | input | TIME_W | Minimum integration time in system cycles |
| fm_o | output | 1 | Sensor master clock pin |
| icg_o | output | 1 | Sensor clear gate pin |
| sh_o | output | 1 | Sensor transfer gate pin |
| strobe_o | output | 1 | One-cycle ADC conversion strobe |
| pix_idx_o | output | $clog2(N_LEAD+N_IMAGE+N_TRAIL) | Index of the pixel slot being sampled |
| frame_start_o | output | 1 | Pulse on the first strobe of a frame |
| frame_done_o | output | 1 | Pulse one cycle after the last strobe |
| integ_stamp_o | output | TIME_W | Cycle number of the last transfer-gate fall |

## Verification
The start request is first held low, which shows that nothing leaves idle without a request. It is then held high with a zero minimum, which exposes the back-to-back frame spacing and the alignment of the clear-gate edge to the master clock phase. A large minimum integration time then forces the next readout to wait on the timer rather than on the frame end. Single-cycle start pulses test the exact edge at which a request is sampled. A second instance with inverted pins is compared against the same reference, so that a fault in the polarity path shows up even when the logical sequence is correct.

// File: rtl/ccd_pkg.sv
package ccd_pkg;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_LEAD,
        SEQ_SH_HIGH,
        SEQ_TAIL,
        SEQ_READ
    } seq_state_t;

    typedef struct packed {
        logic fm;
        logic icg;
        logic sh;
    } sensor_pins_t;

    function automatic int ns_to_cyc(input int ns, input int mhz);
        int c;
        c = (ns * mhz + 999) / 1000;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/ccd_fm_gen.sv
module ccd_fm_gen #(
    parameter int HALF_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    output logic fm_o,
    output logic rise_tick_o
);
    localparam int HC_W = $clog2(HALF_CYC + 1);

    logic [HC_W-1:0] half_cnt_q;
    logic            fm_q;
    logic            wrap;

    assign wrap        = (half_cnt_q == HC_W'(HALF_CYC - 1));
    assign rise_tick_o = wrap && !fm_q;
    assign fm_o        = fm_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            half_cnt_q <= '0;
            fm_q       <= 1'b0;
        end else if (wrap) begin
            half_cnt_q <= '0;
            fm_q       <= ~fm_q;
        end else begin
            half_cnt_q <= half_cnt_q + 1'b1;
        end
    end

    // R1
    rise_tick_chk: assert property (@(posedge clk) disable iff (rst)
        rise_tick_o |=> $rose(fm_q));

endmodule

// File: rtl/ccd_gate_seq.sv
module ccd_gate_seq
    import ccd_pkg::*;
#(
    parameter int LEAD_CYC = 10,
    parameter int SH_CYC   = 15,
    parameter int TAIL_CYC = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic met_i,
    input  logic rise_tick_i,
    input  logic frame_done_i,
    output logic icg_o,
    output logic sh_o,
    output logic go_o,
    output logic sh_fall_o
);
    localparam int CNT_W = $clog2(max3(LEAD_CYC, SH_CYC, TAIL_CYC) + 1);
    localparam int GAP_W = $clog2(LEAD_CYC + SH_CYC + TAIL_CYC + 2) + 1;

    seq_state_t       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             icg_q, sh_q;
    logic             cnt_zero;

    assign cnt_zero  = (cnt_q == '0);
    assign go_o      = (state_q == SEQ_TAIL) && cnt_zero && rise_tick_i;
    assign sh_fall_o = (state_q == SEQ_SH_HIGH) && cnt_zero;
    assign icg_o     = icg_q;
    assign sh_o      = sh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
            icg_q   <= 1'b1;
            sh_q    <= 1'b0;
        end else begin
            case (state_q)
                SEQ_IDLE: if (start_i && met_i) begin
                    state_q <= SEQ_LEAD;
                    icg_q   <= 1'b0;
                    cnt_q   <= CNT_W'(LEAD_CYC - 1);
                end
                SEQ_LEAD: if (cnt_zero) begin
                    state_q <= SEQ_SH_HIGH;
                    sh_q    <= 1'b1;
                    cnt_q   <= CNT_W'(SH_CYC - 1);
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
                SEQ_SH_HIGH: if (cnt_zero) begin
                    state_q <= SEQ_TAIL;
                    sh_q    <= 1'b0;
                    cnt_q   <= CNT_W'(TAIL_CYC - 1);
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
                SEQ_TAIL: if (!cnt_zero) begin
                    cnt_q <= cnt_q - 1'b1;
                end else if (rise_tick_i) begin
                    state_q <= SEQ_READ;
                    icg_q   <= 1'b1;
                end
                SEQ_READ: if (frame_done_i) state_q <= SEQ_IDLE;
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    // Edge-spacing monitor: cycles since the last change on either gate.
    logic             icg_d1, sh_d1;
    logic [GAP_W-1:0] gap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            icg_d1 <= 1'b1;
            sh_d1  <= 1'b0;
            gap_q  <= '0;
        end else begin
            icg_d1 <= icg_q;
            sh_d1  <= sh_q;
            if ((icg_q != icg_d1) || (sh_q != sh_d1)) gap_q <= GAP_W'(1);
            else if (!(&gap_q))                       gap_q <= gap_q + 1'b1;
        end
    end

    // R3
    lead_gap_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sh_q) |-> (gap_q == GAP_W'(LEAD_CYC)) && !icg_q);

    // R4
    sh_width_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(sh_q) |-> (gap_q == GAP_W'(SH_CYC)) && !icg_q);

    // R5
    tail_gap_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(icg_q) |-> (gap_q >= GAP_W'(TAIL_CYC)) && !sh_q);

    // R8
    start_gate_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(icg_q) |-> $past(start_i && met_i));

endmodule

// File: rtl/ccd_integ_timer.sv
module ccd_integ_timer #(
    parameter int TIME_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sh_fall_i,
    input  logic [TIME_W-1:0] min_int_i,
    output logic              met_o,
    output logic [TIME_W-1:0] stamp_o
);
    logic [TIME_W-1:0] tick_q, elapsed_q, stamp_q;

    assign met_o   = (elapsed_q >= min_int_i);
    assign stamp_o = stamp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_q    <= '0;
            elapsed_q <= '1;
            stamp_q   <= '0;
        end else begin
            tick_q <= tick_q + 1'b1;
            if (sh_fall_i) begin
                elapsed_q <= '0;
                stamp_q   <= tick_q + 1'b1;
            end else if (!(&elapsed_q)) begin
                elapsed_q <= elapsed_q + 1'b1;
            end
        end
    end

    // R9
    stamp_chk: assert property (@(posedge clk) disable iff (rst)
        sh_fall_i |=> (stamp_q == tick_q) && (elapsed_q == '0));

endmodule

// File: rtl/ccd_pixel_ctr.sv
module ccd_pixel_ctr #(
    parameter int N_PIX = 13,
    parameter int PIX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go_i,
    input  logic             rise_tick_i,
    input  logic             fm_i,
    output logic             strobe_o,
    output logic [PIX_W-1:0] idx_o,
    output logic             frame_start_o,
    output logic             frame_done_o
);
    localparam logic [PIX_W-1:0] LAST = PIX_W'(N_PIX - 1);

    logic             active_q, skip_q, strobe_q, fstart_q, done_q;
    logic [PIX_W-1:0] idx_q;

    assign strobe_o      = strobe_q;
    assign idx_o         = idx_q;
    assign frame_start_o = fstart_q;
    assign frame_done_o  = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            skip_q   <= 1'b0;
            strobe_q <= 1'b0;
            fstart_q <= 1'b0;
            done_q   <= 1'b0;
            idx_q    <= '0;
        end else begin
            strobe_q <= 1'b0;
            fstart_q <= 1'b0;
            done_q   <= 1'b0;
            if (go_i) begin
                active_q <= 1'b1;
                skip_q   <= 1'b1;
                strobe_q <= 1'b1;
                fstart_q <= 1'b1;
                idx_q    <= '0;
            end else if (active_q && strobe_q && (idx_q == LAST)) begin
                active_q <= 1'b0;
                done_q   <= 1'b1;
            end else if (active_q && rise_tick_i) begin
                if (skip_q) begin
                    skip_q <= 1'b0;
                end else begin
                    skip_q   <= 1'b1;
                    strobe_q <= 1'b1;
                    idx_q    <= idx_q + 1'b1;
                end
            end
        end
    end

    // R6
    strobe_edge_chk: assert property (@(posedge clk) disable iff (rst)
        strobe_q |-> $rose(fm_i));

    // R6
    idx_range_chk: assert property (@(posedge clk) disable iff (rst)
        idx_q <= LAST);

    // R5
    fstart_chk: assert property (@(posedge clk) disable iff (rst)
        fstart_q |-> strobe_q && (idx_q == '0));

    // R7
    done_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |-> $past(strobe_q) && ($past(idx_q) == LAST));

endmodule

// File: rtl/ccd_timing_gen.sv
module ccd_timing_gen
    import ccd_pkg::*;
#(
    parameter int SYS_CLK_MHZ = 250,
    parameter int FM_HALF_NS  = 500,
    parameter int LEAD_NS     = 500,
    parameter int SH_HIGH_NS  = 1200,
    parameter int TAIL_NS     = 5000,
    parameter int N_LEAD      = 32,
    parameter int N_IMAGE     = 1500,
    parameter int N_TRAIL     = 14,
    parameter int TIME_W      = 32,
    parameter bit INVERT      = 1'b0
) (
    input  logic                                          clk,
    input  logic                                          rst,
    input  logic                                          start_i,
    input  logic [TIME_W-1:0]                             min_int_i,
    output logic                                          fm_o,
    output logic                                          icg_o,
    output logic                                          sh_o,
    output logic                                          strobe_o,
    output logic [$clog2(N_LEAD+N_IMAGE+N_TRAIL)-1:0]     pix_idx_o,
    output logic                                          frame_start_o,
    output logic                                          frame_done_o,
    output logic [TIME_W-1:0]                             integ_stamp_o
);
    localparam int HALF_CYC = ns_to_cyc(FM_HALF_NS, SYS_CLK_MHZ);
    localparam int LEAD_CYC = ns_to_cyc(LEAD_NS, SYS_CLK_MHZ);
    localparam int SH_CYC   = ns_to_cyc(SH_HIGH_NS, SYS_CLK_MHZ);
    localparam int TAIL_CYC = ns_to_cyc(TAIL_NS, SYS_CLK_MHZ);
    localparam int N_PIX    = N_LEAD + N_IMAGE + N_TRAIL;
    localparam int PIX_W    = $clog2(N_PIX);

    logic         fm, rise_tick, met, go, sh_fall, done;
    sensor_pins_t pins_log, pins_drv;

    ccd_fm_gen #(.HALF_CYC(HALF_CYC)) u_fm (
        .clk(clk), .rst(rst), .fm_o(fm), .rise_tick_o(rise_tick)
    );

    ccd_integ_timer #(.TIME_W(TIME_W)) u_timer (
        .clk(clk), .rst(rst), .sh_fall_i(sh_fall), .min_int_i(min_int_i),
        .met_o(met), .stamp_o(integ_stamp_o)
    );

    ccd_gate_seq #(.LEAD_CYC(LEAD_CYC), .SH_CYC(SH_CYC), .TAIL_CYC(TAIL_CYC)) u_seq (
        .clk(clk), .rst(rst), .start_i(start_i), .met_i(met),
        .rise_tick_i(rise_tick), .frame_done_i(done),
        .icg_o(pins_log.icg), .sh_o(pins_log.sh), .go_o(go), .sh_fall_o(sh_fall)
    );

    ccd_pixel_ctr #(.N_PIX(N_PIX), .PIX_W(PIX_W)) u_pix (
        .clk(clk), .rst(rst), .go_i(go), .rise_tick_i(rise_tick), .fm_i(fm),
        .strobe_o(strobe_o), .idx_o(pix_idx_o),
        .frame_start_o(frame_start_o), .frame_done_o(done)
    );

    assign pins_log.fm  = fm;
    assign frame_done_o = done;

    generate
        if (INVERT) begin : g_inv
            assign pins_drv = ~pins_log;
        end else begin : g_direct
            assign pins_drv = pins_log;
        end
    endgenerate

    assign fm_o  = pins_drv.fm;
    assign icg_o = pins_drv.icg;
    assign sh_o  = pins_drv.sh;

    // R5
    icg_align_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pins_log.icg) |-> $rose(fm) && frame_start_o);

endmodule

// File: tb/ccd_timing_gen_tb_top.sv
`timescale 1ns/1ps
module ccd_timing_gen_tb_top;
    localparam int MHZ = 250, HALF_NS = 16, LEAD_NS = 40, SHH_NS = 60, TAIL_NS = 48;
    localparam int NL = 3, NI = 8, NT = 2;
    localparam int NPIX = NL + NI + NT;
    localparam int PW = $clog2(NPIX);
    localparam int TW = 32;

    function automatic int cyc(input int ns);
        int c;
        c = (ns * MHZ + 999) / 1000;
        return (c < 1) ? 1 : c;
    endfunction

    localparam int H = cyc(HALF_NS), L = cyc(LEAD_NS), W = cyc(SHH_NS), T = cyc(TAIL_NS);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [TW-1:0] min_int = '0;

    always #2 clk = ~clk;

    logic fm, icg, sh, stb, fst, fdn;
    logic [PW-1:0] idx;
    logic [TW-1:0] stamp;
    logic fm_n, icg_n, sh_n, stb_n, fst_n, fdn_n;
    logic [PW-1:0] idx_n;
    logic [TW-1:0] stamp_n;

    ccd_timing_gen #(.SYS_CLK_MHZ(MHZ), .FM_HALF_NS(HALF_NS), .LEAD_NS(LEAD_NS),
        .SH_HIGH_NS(SHH_NS), .TAIL_NS(TAIL_NS), .N_LEAD(NL), .N_IMAGE(NI),
        .N_TRAIL(NT), .TIME_W(TW), .INVERT(1'b0)) dut_i (
        .clk(clk), .rst(rst), .start_i(start), .min_int_i(min_int),
        .fm_o(fm), .icg_o(icg), .sh_o(sh), .strobe_o(stb), .pix_idx_o(idx),
        .frame_start_o(fst), .frame_done_o(fdn), .integ_stamp_o(stamp));

    ccd_timing_gen #(.SYS_CLK_MHZ(MHZ), .FM_HALF_NS(HALF_NS), .LEAD_NS(LEAD_NS),
        .SH_HIGH_NS(SHH_NS), .TAIL_NS(TAIL_NS), .N_LEAD(NL), .N_IMAGE(NI),
        .N_TRAIL(NT), .TIME_W(TW), .INVERT(1'b1)) dut_inv (
        .clk(clk), .rst(rst), .start_i(start), .min_int_i(min_int),
        .fm_o(fm_n), .icg_o(icg_n), .sh_o(sh_n), .strobe_o(stb_n), .pix_idx_o(idx_n),
        .frame_start_o(fst_n), .frame_done_o(fdn_n), .integ_stamp_o(stamp_n));

    int checks = 0;
    int fails = 0;

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
        end
    endtask

    // Behavioural reference: walks the readout as a timeline of cycle counts.
    longint k = 0;
    longint last_fall = -64'sd1000000000;
    logic   s_start = 1'b0;
    longint s_min = 0;
    logic   e_fm = 1'b0, e_icg = 1'b1, e_sh = 1'b0, e_stb = 1'b0, e_fst = 1'b0, e_fdn = 1'b0;
    int     e_idx = 0;
    longint e_stamp = 0;
    logic   model_on = 1'b0;

    task automatic adv();
        @(posedge clk);
        k++;
        e_fm  = ((k / H) % 2) == 1;
        e_stb = 1'b0;
        e_fst = 1'b0;
        e_fdn = 1'b0;
        s_start = start;
        s_min   = longint'(min_int);
    endtask

    initial begin
        @(negedge rst);
        model_on = 1'b1;
        forever begin
            do adv(); while (!(s_start && (k - last_fall - 1 >= s_min)));
            e_icg = 1'b0;
            repeat (L) adv();
            e_sh = 1'b1;
            repeat (W) adv();
            e_sh = 1'b0;
            last_fall = k;
            e_stamp = k;
            repeat (T) adv();
            while ((k % (2 * H)) != H) adv();
            e_icg = 1'b1; e_stb = 1'b1; e_fst = 1'b1; e_idx = 0;
            for (int j = 1; j < NPIX; j++) begin
                repeat (4 * H) adv();
                e_stb = 1'b1;
                e_idx = j;
            end
            adv();
            e_fdn = 1'b1;
            adv();
        end
    end

    int frames_seen = 0;
    always @(negedge clk) begin
        if (!rst && model_on) begin
            chk("R1 fm", fm, e_fm);
            chk("R3 R5 R8 icg", icg, e_icg);
            chk("R3 R4 sh", sh, e_sh);
            chk("R6 strobe", stb, e_stb);
            chk("R6 pixel index", idx, e_idx);
            chk("R5 frame_start", fst, e_fst);
            chk("R7 frame_done", fdn, e_fdn);
            chk("R9 stamp", stamp, e_stamp);
            chk("R10 inverted fm", fm_n, !e_fm);
            chk("R10 inverted icg", icg_n, !e_icg);
            chk("R10 inverted sh", sh_n, !e_sh);
            chk("R10 strobe not inverted", stb_n, e_stb);
            if (fdn) frames_seen++;
        end
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (4) @(negedge clk);
        // R2: reset levels
        chk("R2 reset icg", icg, 1);
        chk("R2 reset sh", sh, 0);
        chk("R2 reset fm", fm, 0);
        chk("R2 reset strobe", stb, 0);
        chk("R2 reset index", idx, 0);
        chk("R2 reset stamp", stamp, 0);
        @(negedge clk);
        rst = 1'b0;
        // R8: no request, stays idle
        repeat (60) @(negedge clk);
        chk("R2 R8 idle icg", icg, 1);
        // back-to-back frames with zero minimum
        start = 1'b1;
        repeat (900) @(negedge clk);
        // R8: minimum integration stretches the start
        min_int = 32'd700;
        repeat (2000) @(negedge clk);
        start = 1'b0;
        repeat (300) @(negedge clk);
        min_int = 32'd40;
        start = 1'b1;
        repeat (700) @(negedge clk);
        start = 1'b0;
        // single-cycle requests
        for (int i = 0; i < 6; i++) begin
            repeat (150 + 37 * i) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        min_int = 32'd5;
        start = 1'b1;
        repeat (600) @(negedge clk);
        start = 1'b0;
        repeat (400) @(negedge clk);
        // R7: frames completed
        checks++;
        if (frames_seen < 6) begin
            fails++;
            $display("FAIL R7 frame count: actual %0d expected at least 6", frames_seen);
        end
        summary();
    end

endmodule